// File: doc/BRIEF.md
# Write Burst Disconnect Decision Logic

This block sits beside the target side of a bridge and decides, on every accepted data phase of an incoming write burst, whether the target has to stop the burst once the current transfer completes. The decision depends on the write command class, the DWORD address of the phase, the programmed cache line size and one control bit. For posted traffic it also depends on how many DWORD slots the posted data buffer still has free.

The target logic drives `dphase_valid` for each data phase it accepts. It pulses `xact_start` at the address phase of every new write. `disc` goes high in the same cycle as the phase that must be the last one. It then stays high until the next transaction begins, so the bus logic can sample it at any time before that.

Top module: `wdb_disconnect_ctrl`

## Requirements
- R1: When `xact_type` is 2'b00 (delayed write), `disc` is 1 in the cycle of every data phase.
- R2: When `xact_type` is 2'b01 (posted memory write) and bit 1 of `ctl_reg` is 0, a data phase raises `disc` when the low PAGE_LOG2 bits of `dw_addr` are all ones, which is the last DWORD of a 4 KB page at the default width. No other bit of `ctl_reg` has any effect.
- R3: When `xact_type` is 2'b01 and bit 1 of `ctl_reg` is 1, a data phase raises `disc` at the last DWORD of a cache line, meaning `dw_addr` modulo `cls` equals `cls`-1. This applies only when `cls` is a legal size of 1, 2, 4, 8 or 16 DWORDs. Any other size, zero included, falls back to the page rule of R2.
- R4: When `xact_type` is 2'b10 (memory write and invalidate) and `cls` is 16, a data phase raises `disc` at the last DWORD of each 16-DWORD aligned block, whatever the buffer space.
- R5: When `xact_type` is 2'b10 and `cls` is 1, 2, 4 or 8, a data phase at a cache line end raises `disc` only if `buf_free` is less than `cls`.
- R6: When `xact_type` is 2'b10 and `cls` is not a legal size (zero or any value other than 1, 2, 4, 8 or 16), the page rule of R2 applies.
- R7: For both posted types (2'b01 and 2'b10), a data phase with `buf_free` equal to 0 raises `disc`. `buf_free` counts the free DWORD slots left after the current phase is stored.
- R8: `disc` rises only in a data-phase cycle and stays high until `xact_start`. In a `xact_start` cycle without a data phase, `disc` is 0.
- R9: While reset is applied and no data phase is presented, `disc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xact_start | input | 1 | Pulse at the address phase of a new write |
| xact_type | input | 2 | 00 delayed write, 01 posted memory write, 10 memory write and invalidate |
| dphase_valid | input | 1 | A data phase is accepted this cycle |
| dw_addr | input | ADDR_W | DWORD address of the current data phase |
| cls | input | CLS_W | Cache line size in DWORDs |
| ctl_reg | input | 8 | Chip control register; bit 1 selects line-boundary disconnect for posted writes |
| buf_free | input | FREE_W | Free posted buffer DWORD slots after the current phase |
| disc | output | 1 | Disconnect after the current transfer |

## Verification
The bench builds the block with ADDR_W=8 and PAGE_LOG2=6. With these values a page ends every 64 DWORDs, so a sweep of 128 addresses crosses two page ends as well as many line ends. Within that sweep it combines every command class, both control bit values, the legal line sizes plus 0, 3, 12 and 32, and free counts on both sides of each line size. This covers every boundary rule, the fallbacks for illegal sizes and the full-buffer case. After each phase it also checks that `disc` holds over an idle cycle and clears on the next start.

// File: rtl/wdb_pkg.sv
package wdb_pkg;

    typedef enum logic [1:0] {
        WR_DELAYED = 2'b00,
        WR_POSTED  = 2'b01,
        WR_MWI     = 2'b10,
        WR_RSVD    = 2'b11
    } wr_kind_e;

    typedef struct packed {
        logic disc;
    } disc_state_t;

    localparam int CTL_LINE_BIT = 1;

endpackage

// File: rtl/wdb_line_decode.sv
module wdb_line_decode #(
    parameter int CLS_W     = 8,
    parameter int LINE_LOG2 = 4
) (
    input  logic [CLS_W-1:0]     cls,
    output logic                 legal,
    output logic                 is_max,
    output logic [LINE_LOG2-1:0] mask
);
    localparam int NSIZES = LINE_LOG2 + 1;

    logic [NSIZES-1:0] match;

    generate
        for (genvar k = 0; k < NSIZES; k++) begin : g_size
            assign match[k] = (cls == CLS_W'(1 << k));
        end
    endgenerate

    always_comb begin
        legal  = |match;
        is_max = match[LINE_LOG2];
        mask   = '0;
        for (int k = 0; k < NSIZES; k++) begin
            if (match[k]) begin
                mask = LINE_LOG2'((1 << k) - 1);
            end
        end
    end

endmodule

// File: rtl/wdb_boundary_eval.sv
module wdb_boundary_eval
    import wdb_pkg::*;
#(
    parameter int ADDR_W    = 30,
    parameter int PAGE_LOG2 = 10,
    parameter int LINE_LOG2 = 4,
    parameter int CLS_W     = 8,
    parameter int FREE_W    = 8
) (
    input  wr_kind_e             kind,
    input  logic [ADDR_W-1:0]    dw_addr,
    input  logic [CLS_W-1:0]     cls,
    input  logic                 line_mode,
    input  logic [FREE_W-1:0]    buf_free,
    input  logic                 legal,
    input  logic                 is_max,
    input  logic [LINE_LOG2-1:0] mask,
    output logic                 hit
);
    logic page_end;
    logic line_end;
    logic buf_full;
    logic no_room;

    always_comb begin
        page_end = &dw_addr[PAGE_LOG2-1:0];
        line_end = legal && ((dw_addr[LINE_LOG2-1:0] & mask) == mask);
        buf_full = (buf_free == '0);
        no_room  = 32'(buf_free) < 32'(cls);

        unique case (kind)
            WR_POSTED: begin
                if (line_mode && legal) begin
                    hit = buf_full || line_end;
                end else begin
                    hit = buf_full || page_end;
                end
            end
            WR_MWI: begin
                if (is_max) begin
                    hit = buf_full || line_end;
                end else if (legal) begin
                    hit = buf_full || (line_end && no_room);
                end else begin
                    hit = buf_full || page_end;
                end
            end
            default: hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/wdb_disconnect_ctrl.sv
module wdb_disconnect_ctrl
    import wdb_pkg::*;
#(
    parameter int ADDR_W    = 30,
    parameter int PAGE_LOG2 = 10,
    parameter int LINE_LOG2 = 4,
    parameter int CLS_W     = 8,
    parameter int FREE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xact_start,
    input  logic [1:0]        xact_type,
    input  logic              dphase_valid,
    input  logic [ADDR_W-1:0] dw_addr,
    input  logic [CLS_W-1:0]  cls,
    input  logic [7:0]        ctl_reg,
    input  logic [FREE_W-1:0] buf_free,
    output logic              disc
);
    logic                 legal;
    logic                 is_max;
    logic [LINE_LOG2-1:0] mask;
    logic                 hit;
    disc_state_t          st_d;
    disc_state_t          st_q;

    wdb_line_decode #(
        .CLS_W     (CLS_W),
        .LINE_LOG2 (LINE_LOG2)
    ) u_decode (
        .cls    (cls),
        .legal  (legal),
        .is_max (is_max),
        .mask   (mask)
    );

    wdb_boundary_eval #(
        .ADDR_W    (ADDR_W),
        .PAGE_LOG2 (PAGE_LOG2),
        .LINE_LOG2 (LINE_LOG2),
        .CLS_W     (CLS_W),
        .FREE_W    (FREE_W)
    ) u_eval (
        .kind      (wr_kind_e'(xact_type)),
        .dw_addr   (dw_addr),
        .cls       (cls),
        .line_mode (ctl_reg[CTL_LINE_BIT]),
        .buf_free  (buf_free),
        .legal     (legal),
        .is_max    (is_max),
        .mask      (mask),
        .hit       (hit)
    );

    always_comb begin
        st_d      = st_q;
        if (xact_start) begin
            st_d.disc = 1'b0;
        end
        if (dphase_valid && hit) begin
            st_d.disc = 1'b1;
        end
        disc = (dphase_valid && hit) || (st_q.disc && !xact_start);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wdb_disconnect_chk.sv
module wdb_disconnect_chk #(
    parameter int FREE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xact_start,
    input logic [1:0]        xact_type,
    input logic              dphase_valid,
    input logic [FREE_W-1:0] buf_free,
    input logic              disc
);
    // R1: delayed writes stop after each transfer
    a_r1_delayed_single: assert property (@(posedge clk) disable iff (!rst_n)
        (dphase_valid && xact_type == 2'b00) |-> disc);

    // R7: a full buffer forces the stop for posted classes
    a_r7_buffer_full: assert property (@(posedge clk) disable iff (!rst_n)
        (dphase_valid && (xact_type == 2'b01 || xact_type == 2'b10) && buf_free == '0) |-> disc);

    // R8: request held until the next start
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        disc |=> (disc || xact_start));

    // R8: start without data clears
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_start && !dphase_valid) |-> !disc);

    // R8: rise only with a data phase
    a_r8_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disc) |-> dphase_valid);

endmodule

bind wdb_disconnect_ctrl wdb_disconnect_chk #(
    .FREE_W (FREE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xact_start   (xact_start),
    .xact_type    (xact_type),
    .dphase_valid (dphase_valid),
    .buf_free     (buf_free),
    .disc         (disc)
);

// File: tb/sim_wdb_disconnect_ctrl.sv
module sim_wdb_disconnect_ctrl;
    localparam int ADDR_W    = 8;
    localparam int PAGE_LOG2 = 6;
    localparam int PAGE      = 1 << PAGE_LOG2;
    localparam int CLS_W     = 8;
    localparam int FREE_W    = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              xact_start = 1'b0;
    logic [1:0]        xact_type = 2'b00;
    logic              dphase_valid = 1'b0;
    logic [ADDR_W-1:0] dw_addr = '0;
    logic [CLS_W-1:0]  cls = '0;
    logic [7:0]        ctl_reg = '0;
    logic [FREE_W-1:0] buf_free = '0;
    logic              disc;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    wdb_disconnect_ctrl #(
        .ADDR_W    (ADDR_W),
        .PAGE_LOG2 (PAGE_LOG2),
        .LINE_LOG2 (4),
        .CLS_W     (CLS_W),
        .FREE_W    (FREE_W)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .xact_start   (xact_start),
        .xact_type    (xact_type),
        .dphase_valid (dphase_valid),
        .dw_addr      (dw_addr),
        .cls          (cls),
        .ctl_reg      (ctl_reg),
        .buf_free     (buf_free),
        .disc         (disc)
    );

    task automatic check(input string req, input logic act, input logic exp,
                         input int t, input int c, input int k, input int a, input int f);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s type=%0d cls=%0d ctl=%0d addr=%0d free=%0d actual=%0b expected=%0b",
                     req, t, c, k, a, f, act, exp);
        end
    endtask

    function automatic logic ref_disc(int t, int c, int k, int a, int f);
        logic page_end;
        logic legal;
        logic line_end;
        page_end = (a % PAGE) == PAGE - 1;
        legal    = (c == 1) || (c == 2) || (c == 4) || (c == 8) || (c == 16);
        line_end = legal && ((a % (legal ? c : 1)) == c - 1);
        if (t == 0) return 1'b1;
        if (f == 0) return 1'b1;
        if (t == 1) return (k == 1 && legal) ? line_end : page_end;
        if (c == 16) return line_end;
        if (legal) return line_end && (f < c);
        return page_end;
    endfunction

    function automatic string req_of(int t, int c, int k, int f);
        logic legal;
        legal = (c == 1) || (c == 2) || (c == 4) || (c == 8) || (c == 16);
        if (t == 0) return "R1";
        if (f == 0) return "R7";
        if (t == 1) return (k == 1) ? "R3" : "R2";
        if (c == 16) return "R4";
        if (legal) return "R5";
        return "R6";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int cls_l[9]  = '{0, 1, 2, 3, 4, 8, 12, 16, 32};
        int free_l[6] = '{0, 1, 3, 8, 15, 40};
        logic e;
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check("R9", disc, 1'b0, 0, 0, 0, 0, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R8", disc, 1'b0, 0, 0, 0, 0, 0);
        @(posedge clk);
        #1;
        for (int t = 0; t < 3; t++) begin
            for (int ci = 0; ci < 9; ci++) begin
                for (int k = 0; k < 2; k++) begin
                    for (int a = 0; a < 128; a++) begin
                        for (int fi = 0; fi < 6; fi++) begin
                            e = ref_disc(t, cls_l[ci], k, a, free_l[fi]);
                            xact_type    = 2'(t);
                            cls          = CLS_W'(cls_l[ci]);
                            ctl_reg      = {6'(a >> 1), 1'(k), 1'(a)};
                            dw_addr      = ADDR_W'(a);
                            buf_free     = FREE_W'(free_l[fi]);
                            dphase_valid = 1'b1;
                            @(negedge clk);
                            check(req_of(t, cls_l[ci], k, free_l[fi]), disc, e,
                                  t, cls_l[ci], k, a, free_l[fi]);
                            @(posedge clk);
                            #1 dphase_valid = 1'b0;
                            @(negedge clk);
                            check("R8", disc, e, t, cls_l[ci], k, a, free_l[fi]);
                            @(posedge clk);
                            #1 xact_start = 1'b1;
                            @(negedge clk);
                            check("R8", disc, 1'b0, t, cls_l[ci], k, a, free_l[fi]);
                            @(posedge clk);
                            #1 xact_start = 1'b0;
                        end
                    end
                end
            end
        end
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule